// File: doc/BRIEF.md
# Bit-Tap Interval Timer

This block keeps a free-running 64-bit time-base counter and raises a periodic event each time one chosen bit of that counter goes from 0 to 1. Two channels share the counter. One is a fixed-interval timer and the other is the first stage of a watchdog. Each channel picks its own tap bit, so its period is a power of two in counts of the time base.

A 32-bit control register holds the period selection and the interrupt enables for both channels. A 32-bit status register holds one sticky event flag per channel. Software clears a flag by writing a one to it. The interrupt request outputs are levels: each is high while its flag and its enable are both set. Software reaches the registers through a plain register write strobe and a combinational read mux. The same port loads either 32-bit half of the time base.

A build parameter selects how the tap is chosen. In extended mode the tap is computed from a 2-bit base field and a 4-bit extension field. In table mode the base field indexes a four-entry table of bit positions that is fixed when the block is built.

Top module: `tap_timer`

## Requirements
- R1: After reset the control register, the status register, both halves of the time base and both interrupt outputs are zero.
- R2: The time base adds one at each clock edge where `tickEn` is high and holds otherwise. Register select 2 writes bits [31:0] and select 3 writes bits [63:32]. A written half holds the new value from the next clock, and that write takes priority over a tick in the same cycle. Reads with the same select codes return the halves.
- R3: In extended mode the tap index is 63 minus the 6-bit value {extension, base}. The fixed-interval channel takes its base from control [25:24] and its extension from [16:13]. The watchdog channel takes its base from [31:30] and its extension from [20:17].
- R4: An event occurs in the cycle where the tapped bit reads 1 after reading 0 in the previous cycle. A 1-to-0 change and a bit that stays high produce no event. A fixed-interval event sets status bit 26 and a watchdog event sets status bit 30. The flag is visible from the clock edge that ends the event cycle.
- R5: `fitIrq` equals status bit 26 AND control bit 23. `wdtIrq` equals status bit 30 AND control bit 27.
- R6: A write to the status register (select 1) clears every flag written as 1 and leaves the flags written as 0 unchanged.
- R7: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: A control write (select 0) does not by itself cause an event. The previous tap value is re-sampled from the new selection when the control register is written.
- R9: With `EXT_MODE` = 0, the base field selects entry `base` of the channel's tap table, whose entry i sits at bits [6i+5:6i], and the extension field is ignored.

Read select 0 returns the control register, read select 1 returns the status register, and read selects 2 and 3 return the time-base halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time-base count enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 control, 1 status, 2 time-base low, 3 time-base high |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Read source, same encoding as `wrSel` |
| rdData | output | 32 | Read data (combinational) |
| fitIrq | output | 1 | Fixed-interval interrupt request |
| wdtIrq | output | 1 | Watchdog interrupt request |

## Verification
The timing follows from the block's registers.

- **Register writes.** A control or time-base write lands at the edge that ends the write cycle. It is readable in the next cycle, because the read path has no register.
- **Event flags.** A flag appears one edge after the cycle in which the time base first holds a value with the tap bit set.
- **Interrupts.** Each interrupt follows its flag in the same cycle.

The bench drives every input at the falling edge. After each tick burst it leaves one idle cycle before sampling flags, interrupts and counter halves at the next falling edge. After a reload it inserts an idle cycle and then a status clear, so that any transition created by the reload itself is gone before measurement starts.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

  localparam int REG_W  = 32;
  localparam int TB_W   = 64;
  localparam int IDX_W  = $clog2(TB_W);
  localparam int BASE_W = 2;
  localparam int EXT_W  = 4;
  localparam int NUM_CH = 2;
  localparam int TAPS_W = (1 << BASE_W) * IDX_W;

  localparam int CH_FIT = 0;
  localparam int CH_WDT = 1;

  // control field positions
  localparam int CTL_WDT_BASE = 30;
  localparam int CTL_WDT_IE   = 27;
  localparam int CTL_FIT_BASE = 24;
  localparam int CTL_FIT_IE   = 23;
  localparam int CTL_WDT_EXT  = 17;
  localparam int CTL_FIT_EXT  = 13;

  // status flag positions
  localparam int ST_FIT = 26;
  localparam int ST_WDT = 30;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_TB_LO = 2'd2,
    SEL_TB_HI = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [EXT_W-1:0]  ext;
  } tapSel_t;

  typedef struct packed {
    logic                    ctrlWr;
    logic                    tbLoWr;
    logic                    tbHiWr;
    logic [REG_W-1:0]        data;
    tapSel_t [NUM_CH-1:0]    nextSel;
  } strobe_t;

endpackage

// File: rtl/tap_index.sv
module tap_index
  import tap_timer_pkg::*;
#(
  parameter bit                EXT_MODE = 1'b1,
  parameter logic [TAPS_W-1:0] TAPS     = '0
) (
  input  tapSel_t          sel,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] extIdx;
  logic [IDX_W-1:0] tblIdx;

  assign extIdx = IDX_W'(TB_W - 1) - {sel.ext, sel.base};
  assign tblIdx = TAPS[sel.base*IDX_W +: IDX_W];
  assign idx    = EXT_MODE ? extIdx : tblIdx;

endmodule

// File: rtl/tap_timer_dpath.sv
module tap_timer_dpath
  import tap_timer_pkg::*;
#(
  parameter bit                EXT_MODE = 1'b1,
  parameter logic [TAPS_W-1:0] FIT_TAPS = '0,
  parameter logic [TAPS_W-1:0] WDT_TAPS = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  strobe_t              strobes,
  input  tapSel_t [NUM_CH-1:0] curSel,
  output logic [TB_W-1:0]      tbValue,
  output logic [NUM_CH-1:0]    evt
);

  logic [TB_W-1:0] tbQ;
  logic [TB_W-1:0] tbNext;

  always_comb begin
    tbNext = tbQ;
    if (strobes.tbLoWr)      tbNext[REG_W-1:0]    = strobes.data;
    else if (strobes.tbHiWr) tbNext[TB_W-1:REG_W] = strobes.data;
    else if (tickEn)         tbNext               = tbQ + TB_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) tbQ <= '0;
    else       tbQ <= tbNext;
  end

  assign tbValue = tbQ;

  // R2
  tb_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobes.tbLoWr && !strobes.tbHiWr) |=> tbQ == $past(tbQ) + TB_W'(1));

  // R2
  tb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobes.tbLoWr && !strobes.tbHiWr) |=> $stable(tbQ));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    localparam logic [TAPS_W-1:0] TAPS = (ch == CH_FIT) ? FIT_TAPS : WDT_TAPS;

    logic [IDX_W-1:0] idxCur;
    logic [IDX_W-1:0] idxNext;
    logic             curBit;
    logic             prevQ;

    tap_index #(.EXT_MODE(EXT_MODE), .TAPS(TAPS)) uCur (
      .sel(curSel[ch]),
      .idx(idxCur)
    );

    tap_index #(.EXT_MODE(EXT_MODE), .TAPS(TAPS)) uNext (
      .sel(strobes.nextSel[ch]),
      .idx(idxNext)
    );

    assign curBit  = tbQ[idxCur];
    assign evt[ch] = curBit & ~prevQ;

    always_ff @(posedge clk) begin
      if (!rstN)               prevQ <= 1'b0;
      else if (strobes.ctrlWr) prevQ <= tbQ[idxNext];
      else                     prevQ <= curBit;
    end

    // R4
    single_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
      (evt[ch] && !strobes.ctrlWr && !strobes.tbLoWr && !strobes.tbHiWr) |=> !evt[ch]);

    // R8
    ctrl_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.ctrlWr && !tickEn) |=> !evt[ch]);
  end

endmodule

// File: rtl/tap_timer_ctrl.sv
module tap_timer_ctrl
  import tap_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [REG_W-1:0]     wrData,
  input  logic [1:0]           rdSel,
  input  logic [TB_W-1:0]      tbValue,
  input  logic [NUM_CH-1:0]    evt,
  output strobe_t              strobes,
  output tapSel_t [NUM_CH-1:0] curSel,
  output logic [REG_W-1:0]     rdData,
  output logic                 fitIrq,
  output logic                 wdtIrq
);

  regSel_e          wSel;
  regSel_e          rSel;
  logic [REG_W-1:0] ctrlQ;
  logic             fitFlagQ;
  logic             wdtFlagQ;
  logic             statWr;
  logic             fitEvt;
  logic             wdtEvt;

  assign wSel   = regSel_e'(wrSel);
  assign rSel   = regSel_e'(rdSel);
  assign statWr = wrEn && (wSel == SEL_STAT);
  assign fitEvt = evt[CH_FIT];
  assign wdtEvt = evt[CH_WDT];

  assign strobes.ctrlWr = wrEn && (wSel == SEL_CTRL);
  assign strobes.tbLoWr = wrEn && (wSel == SEL_TB_LO);
  assign strobes.tbHiWr = wrEn && (wSel == SEL_TB_HI);
  assign strobes.data   = wrData;
  assign strobes.nextSel[CH_FIT] = {wrData[CTL_FIT_BASE +: BASE_W], wrData[CTL_FIT_EXT +: EXT_W]};
  assign strobes.nextSel[CH_WDT] = {wrData[CTL_WDT_BASE +: BASE_W], wrData[CTL_WDT_EXT +: EXT_W]};

  assign curSel[CH_FIT] = {ctrlQ[CTL_FIT_BASE +: BASE_W], ctrlQ[CTL_FIT_EXT +: EXT_W]};
  assign curSel[CH_WDT] = {ctrlQ[CTL_WDT_BASE +: BASE_W], ctrlQ[CTL_WDT_EXT +: EXT_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      fitFlagQ <= 1'b0;
      wdtFlagQ <= 1'b0;
    end else begin
      if (strobes.ctrlWr) ctrlQ <= wrData;
      // an event in the same cycle overrides a clear
      fitFlagQ <= fitEvt | (fitFlagQ & ~(statWr & wrData[ST_FIT]));
      wdtFlagQ <= wdtEvt | (wdtFlagQ & ~(statWr & wrData[ST_WDT]));
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rSel)
      SEL_CTRL:  rdData = ctrlQ;
      SEL_STAT: begin
        rdData[ST_FIT] = fitFlagQ;
        rdData[ST_WDT] = wdtFlagQ;
      end
      SEL_TB_LO: rdData = tbValue[REG_W-1:0];
      SEL_TB_HI: rdData = tbValue[TB_W-1:REG_W];
      default:   rdData = '0;
    endcase
  end

  assign fitIrq = fitFlagQ & ctrlQ[CTL_FIT_IE];
  assign wdtIrq = wdtFlagQ & ctrlQ[CTL_WDT_IE];

  // R4
  fit_set_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fitFlagQ) |-> $past(fitEvt));

  // R4
  wdt_set_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtFlagQ) |-> $past(wdtEvt));

  // R6
  fit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wrData[ST_FIT] && !fitEvt) |=> !fitFlagQ);

  // R6
  wdt_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !wrData[ST_WDT] && !wdtEvt) |=> wdtFlagQ == $past(wdtFlagQ));

  // R7
  fit_evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    fitEvt |=> fitFlagQ);

  // R7
  wdt_evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtEvt |=> wdtFlagQ);

endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter bit                EXT_MODE = 1'b1,
  parameter logic [TAPS_W-1:0] FIT_TAPS = {6'd29, 6'd25, 6'd21, 6'd17},
  parameter logic [TAPS_W-1:0] WDT_TAPS = {6'd33, 6'd29, 6'd25, 6'd21}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [REG_W-1:0] rdData,
  output logic             fitIrq,
  output logic             wdtIrq
);

  strobe_t              strobes;
  tapSel_t [NUM_CH-1:0] curSel;
  logic [TB_W-1:0]      tbValue;
  logic [NUM_CH-1:0]    evt;

  tap_timer_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .rdSel  (rdSel),
    .tbValue(tbValue),
    .evt    (evt),
    .strobes(strobes),
    .curSel (curSel),
    .rdData (rdData),
    .fitIrq (fitIrq),
    .wdtIrq (wdtIrq)
  );

  tap_timer_dpath #(
    .EXT_MODE(EXT_MODE),
    .FIT_TAPS(FIT_TAPS),
    .WDT_TAPS(WDT_TAPS)
  ) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .strobes(strobes),
    .curSel (curSel),
    .tbValue(tbValue),
    .evt    (evt)
  );

endmodule

// File: tb/tap_timer_test.sv
module tap_timer_test;

  function automatic logic [31:0] mkCtrl(input int wp, input int wext, input int wie,
                                         input int fp, input int fext, input int fie);
    logic [31:0] c;
    c = '0;
    c[31:30] = wp[1:0];
    c[27]    = wie[0];
    c[25:24] = fp[1:0];
    c[23]    = fie[0];
    c[20:17] = wext[3:0];
    c[16:13] = fext[3:0];
    return c;
  endfunction

  typedef struct packed {
    logic [31:0] ctrl;
    logic [63:0] start;
    logic [7:0]  n;
    logic [31:0] expSt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{mkCtrl(0, 0, 0, 0, 15, 1), 64'h4,                   8'd4, 32'h0400_0000},
    '{mkCtrl(0, 0, 0, 0, 15, 1), 64'h8,                   8'd4, 32'h0000_0000},
    '{mkCtrl(0, 0, 0, 0, 15, 1), 64'hE,                   8'd4, 32'h0000_0000},
    '{mkCtrl(0, 0, 1, 3, 15, 0), 64'h7FFF_FFFF_FFFF_FFFE, 8'd2, 32'h4400_0000},
    '{mkCtrl(2, 9, 1, 1, 0, 0),  64'h0000_0000_01FF_FFFD, 8'd3, 32'h4000_0000},
    '{mkCtrl(3, 15, 0, 2, 5, 1), 64'h0000_01FF_FFFF_FFFF, 8'd1, 32'h0400_0000}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic        wrEn;
  logic [1:0]  wrSel;
  logic [31:0] wrData;
  logic [1:0]  rdSel;
  logic [31:0] rdData;
  logic        fitIrq;
  logic        wdtIrq;
  logic [31:0] rdDataT;
  logic        fitIrqT;
  logic        wdtIrqT;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  tap_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .fitIrq(fitIrq), .wdtIrq(wdtIrq)
  );

  tap_timer #(.EXT_MODE(1'b0)) uutTbl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdDataT), .fitIrq(fitIrqT), .wdtIrq(wdtIrqT)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rdSel = s;
    #1;
    v = rdData;
  endtask

  task automatic rdTb(output logic [63:0] v);
    logic [31:0] lo;
    logic [31:0] hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input logic [31:0] ctrl, input logic [63:0] start);
    wr(2'd0, ctrl);
    wr(2'd2, start[31:0]);
    wr(2'd3, start[63:32]);
    @(negedge clk);
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] t;
    rstN = 1'b0; tickEn = 1'b0; wrEn = 1'b0; wrSel = '0; wrData = '0; rdSel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1", "ctrl after reset", 64'(v), 64'h0);
    rd(2'd1, v); check("R1", "status after reset", 64'(v), 64'h0);
    rdTb(t);     check("R1", "time base after reset", t, 64'h0);
    check("R1", "fitIrq after reset", 64'(fitIrq), 64'h0);
    check("R1", "wdtIrq after reset", 64'(wdtIrq), 64'h0);

    // R2 hold, count, write priority over tick
    repeat (5) @(negedge clk);
    rdTb(t); check("R2", "hold without tick", t, 64'h0);
    ticks(3);
    rdTb(t); check("R2", "count three ticks", t, 64'h3);
    tickEn = 1'b1;
    wr(2'd2, 32'h0000_0100);
    tickEn = 1'b0;
    rdTb(t); check("R2", "low write beats tick", t, 64'h100);

    // R3 R4 R5 R2 vector table
    for (int i = 0; i < NV; i++) begin
      load(VECS[i].ctrl, VECS[i].start);
      ticks(int'(VECS[i].n));
      rd(2'd1, v);
      check("R3/R4", $sformatf("vector %0d status", i), 64'(v), 64'(VECS[i].expSt));
      check("R5", $sformatf("vector %0d fitIrq", i), 64'(fitIrq),
            64'(VECS[i].expSt[26] & VECS[i].ctrl[23]));
      check("R5", $sformatf("vector %0d wdtIrq", i), 64'(wdtIrq),
            64'(VECS[i].expSt[30] & VECS[i].ctrl[27]));
      rdTb(t);
      check("R2", $sformatf("vector %0d time base", i), t,
            VECS[i].start + 64'(VECS[i].n));
    end

    // R6 selective clear
    load(VECS[3].ctrl, VECS[3].start);
    ticks(2);
    rd(2'd1, v); check("R6", "both flags set", 64'(v), 64'h4400_0000);
    wr(2'd1, 32'h0400_0000);
    rd(2'd1, v); check("R6", "clear fixed-interval only", 64'(v), 64'h4000_0000);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, v); check("R6", "zero write keeps flags", 64'(v), 64'h4000_0000);
    check("R6", "wdtIrq kept", 64'(wdtIrq), 64'h1);

    // R7 event and clear in the same cycle
    load(mkCtrl(0, 0, 0, 0, 15, 1), 64'h7);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R7", "event beats clear", 64'(v), 64'h0400_0000);
    wr(2'd1, 32'h0400_0000);
    rd(2'd1, v); check("R6", "later clear works", 64'(v), 64'h0);

    // R8 period change makes no event
    load(mkCtrl(0, 0, 0, 1, 15, 1), 64'h8);
    wr(2'd0, mkCtrl(0, 0, 0, 0, 15, 1));
    repeat (2) @(negedge clk);
    rd(2'd1, v); check("R8", "status after period change", 64'(v), 64'h0);
    check("R8", "fitIrq after period change", 64'(fitIrq), 64'h0);

    // R9 table mode ignores extension
    load(mkCtrl(0, 0, 0, 2, 15, 1), 64'h01FF_FFFF);
    ticks(1);
    rdSel = 2'd1;
    #1;
    check("R9", "table mode status", 64'(rdDataT), 64'h0400_0000);
    check("R9", "table mode fitIrq", 64'(fitIrqT), 64'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule